// File: doc/BRIEF.md
# Ring-Slot Receive Frame Writer

This block takes received Ethernet frames one byte per beat from a stream (valid, data, last) and copies each frame into one fixed-size slot of a packet-buffer RAM. It writes through a single-byte write port. The receive slots form a ring at the bottom of the buffer. A slot pointer picks the slot for the next frame and advances after every completed frame. When the pointer passes the last slot it returns to the first.

When a frame ends, the block records two values for the register block: the slot that was filled and the number of bytes kept in it. It also sets a receive-pending flag, which software clears with a clear strobe. Input is refused while the receive event enable is low, so frames queue upstream and are not dropped. A frame that is larger than a slot is cut to the slot size. Its remaining bytes are taken from the stream and thrown away, so the stream never stalls.

Top module: `rx_slot_writer`

## Requirements
- R1: `inReady` equals `evEnable` in every cycle, including while an oversized frame is being discarded. No byte is taken while `evEnable` is 0.
- R2: Each kept byte is written in the same cycle it is accepted. `memWe` is 1, `memWdata` equals `inData`, and `memAddr` is slot × 2048 + n, where n is the byte's position (starting at 0) inside the frame.
- R3: At most 2048 bytes of a frame are written. Accepted beats after the 2048th byte raise no `memWe`.
- R4: After the clock edge that accepts a frame's last beat, `lastLen` holds the number of bytes kept. This is the frame length, capped at 2048.
- R5: After that same edge, `lastSlot` holds the index of the slot the frame was written into.
- R6: The slot pointer starts a frame at offset 0 of the slot after the previous frame's slot, counted modulo NUM_SLOTS (default 2).
- R7: `rxPending` becomes 1 after the edge that accepts a last beat, and stays 1 until a `pendClear` cycle that does not also accept a last beat. When a completion and a clear fall in the same cycle, the completion wins.
- R8: After reset, the pointer is at slot 0, `rxPending` is 0, and `lastSlot` and `lastLen` are 0.
- R9: `lastSlot` and `lastLen` do not change in any cycle that does not complete a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Stream byte valid |
| inData | input | 8 | Stream byte |
| inLast | input | 1 | Marks the final byte of a frame |
| inReady | output | 1 | Block accepts a byte this cycle |
| evEnable | input | 1 | Receive event enable from the register block |
| pendClear | input | 1 | Clears the receive-pending flag |
| memWe | output | 1 | Buffer RAM byte write enable |
| memAddr | output | clog2(NUM_SLOTS·SLOT_BYTES) | Buffer RAM byte address |
| memWdata | output | 8 | Buffer RAM write data |
| lastSlot | output | clog2(NUM_SLOTS) | Slot of the most recent frame |
| lastLen | output | clog2(SLOT_BYTES+1) | Bytes kept for the most recent frame |
| rxPending | output | 1 | Receive-pending flag |

## Verification
A corrupted byte offset shows up on `memAddr` at the next kept byte. If the counter fails to return to 0, the first byte of the next frame lands at a nonzero offset, which is seen within one cycle of that frame's start. A wrong slot pointer moves every address of the next frame by a multiple of 2048 and makes `lastSlot` wrong one cycle after that frame ends. A faulty truncation bound shows up at byte 2049 as a stray `memWe`, and later as a wrong `lastLen`. The bench keeps its own model of the pointer, offset and flag and compares all outputs in every cycle, so each of these faults is caught in the cycle it first becomes visible.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic accept;  // a stream beat is taken
    logic store;   // the beat's byte goes to RAM
    logic finish;  // the beat closes the frame
  } rxwStrb_t;
endpackage

// File: rtl/rxw_ctrl.sv
module rxw_ctrl
  import rxw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inLast,
  input  logic     evEnable,
  input  logic     pendClear,
  input  logic     slotFull,
  output logic     inReady,
  output rxwStrb_t strb,
  output logic     rxPending
);

  logic takeBeat;

  // intake is gated by the event enable only, so overflow bytes never stall
  assign inReady  = evEnable;
  assign takeBeat = inValid && inReady;

  always_comb begin
    strb        = '0;
    strb.accept = takeBeat;
    strb.store  = takeBeat && !slotFull;
    strb.finish = takeBeat && inLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPending <= 1'b0;
    end else if (strb.finish && evEnable) begin
      rxPending <= 1'b1;
    end else if (pendClear) begin
      rxPending <= 1'b0;
    end
  end

  // R1: nothing is taken while the event is disabled
  a_r1_no_take_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !evEnable |-> !strb.accept);
  // R7: completion raises the flag on the next cycle
  a_r7_pend_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> rxPending);
  // R7: the flag holds until cleared
  a_r7_pend_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxPending && !pendClear) |=> rxPending);
  // R3: a full slot never produces a store
  a_r3_full_no_store: assert property (@(posedge clk) disable iff (!rstN)
    slotFull |-> !strb.store);

endmodule

// File: rtl/rxw_datapath.sv
module rxw_datapath
  import rxw_pkg::*;
#(
  parameter int SLOT_BYTES = 2048,
  parameter int NUM_SLOTS  = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  rxwStrb_t                             strb,
  input  logic [7:0]                           inData,
  output logic                                 slotFull,
  output logic                                 memWe,
  output logic [$clog2(NUM_SLOTS*SLOT_BYTES)-1:0] memAddr,
  output logic [7:0]                           memWdata,
  output logic [(NUM_SLOTS > 1 ? $clog2(NUM_SLOTS) : 1)-1:0] lastSlot,
  output logic [$clog2(SLOT_BYTES+1)-1:0]      lastLen
);

  localparam int LEN_W  = $clog2(SLOT_BYTES + 1);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int ADDR_W = $clog2(NUM_SLOTS * SLOT_BYTES);
  localparam logic [LEN_W-1:0]  SLOT_CAP  = LEN_W'(SLOT_BYTES);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [LEN_W-1:0]  byteOffs;
  logic [SLOT_W-1:0] curSlot;
  logic [SLOT_W-1:0] nextSlot;
  logic [LEN_W-1:0]  keptCount;
  logic [ADDR_W-1:0] slotBase;

  assign slotFull  = (byteOffs == SLOT_CAP);
  assign keptCount = strb.store ? byteOffs + 1'b1 : byteOffs;
  assign nextSlot  = (curSlot == SLOT_LAST) ? '0 : curSlot + 1'b1;
  assign slotBase  = ADDR_W'(curSlot) * ADDR_W'(SLOT_BYTES);

  assign memWe    = strb.store;
  assign memAddr  = slotBase + ADDR_W'(byteOffs);
  assign memWdata = inData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteOffs <= '0;
      curSlot  <= '0;
      lastSlot <= '0;
      lastLen  <= '0;
    end else if (strb.finish) begin
      byteOffs <= '0;
      curSlot  <= nextSlot;
      lastSlot <= curSlot;
      lastLen  <= keptCount;
    end else if (strb.store) begin
      byteOffs <= byteOffs + 1'b1;
    end
  end

  // R3: offset never passes the slot size
  a_r3_offs_bound: assert property (@(posedge clk) disable iff (!rstN)
    byteOffs <= SLOT_CAP);
  // R6: pointer stays inside the ring
  a_r6_slot_range: assert property (@(posedge clk) disable iff (!rstN)
    curSlot <= SLOT_LAST);
  // R9: recorded values hold between completions
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> ($stable(lastSlot) && $stable(lastLen)));
  // R4: a completed frame records between 1 and SLOT_BYTES bytes
  a_r4_len_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (lastLen != '0 && lastLen <= SLOT_CAP));

endmodule

// File: rtl/rx_slot_writer.sv
module rx_slot_writer
  import rxw_pkg::*;
#(
  parameter int SLOT_BYTES = 2048,
  parameter int NUM_SLOTS  = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 inValid,
  input  logic [7:0]                           inData,
  input  logic                                 inLast,
  output logic                                 inReady,
  input  logic                                 evEnable,
  input  logic                                 pendClear,
  output logic                                 memWe,
  output logic [$clog2(NUM_SLOTS*SLOT_BYTES)-1:0] memAddr,
  output logic [7:0]                           memWdata,
  output logic [(NUM_SLOTS > 1 ? $clog2(NUM_SLOTS) : 1)-1:0] lastSlot,
  output logic [$clog2(SLOT_BYTES+1)-1:0]      lastLen,
  output logic                                 rxPending
);

  rxwStrb_t strb;
  logic     slotFull;

  rxw_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inLast    (inLast),
    .evEnable  (evEnable),
    .pendClear (pendClear),
    .slotFull  (slotFull),
    .inReady   (inReady),
    .strb      (strb),
    .rxPending (rxPending)
  );

  rxw_datapath #(
    .SLOT_BYTES (SLOT_BYTES),
    .NUM_SLOTS  (NUM_SLOTS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .inData   (inData),
    .slotFull (slotFull),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .lastSlot (lastSlot),
    .lastLen  (lastLen)
  );

endmodule

// File: tb/rx_slot_writer_bench.sv
module rx_slot_writer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 2048;
  localparam int NSLOT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inLast = 1'b0;
  logic        evEnable = 1'b0;
  logic        pendClear = 1'b0;
  logic        inReady, memWe, rxPending;
  logic [11:0] memAddr;
  logic [7:0]  memWdata;
  logic [0:0]  lastSlot;
  logic [11:0] lastLen;

  int checks = 0;
  int fails = 0;
  // reference model state
  int refSlot = 0, refOffs = 0, refLastSlot = 0, refLastLen = 0, refPend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_slot_writer u_rx_slot_writer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inReady(inReady), .evEnable(evEnable), .pendClear(pendClear),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .lastSlot(lastSlot), .lastLen(lastLen), .rxPending(rxPending)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock of stimulus, starting at a falling edge
  task automatic step(input bit v, input logic [7:0] d, input bit l, input bit en, input bit clr);
    bit acc, st, fin;
    int expAddr;
    inValid = v; inData = d; inLast = l; evEnable = en; pendClear = clr;
    #1;
    acc = v && en;
    st  = acc && (refOffs < SLOT);
    fin = acc && l;
    chk(inReady == en, "R1", int'(inReady), int'(en));
    chk(memWe == st, (refOffs >= SLOT) ? "R3" : "R2", int'(memWe), int'(st));
    if (st) begin
      expAddr = refSlot * SLOT + refOffs;
      chk(int'(memAddr) == expAddr, (refOffs == 0) ? "R6" : "R2", int'(memAddr), expAddr);
      chk(memWdata == d, "R2", int'(memWdata), int'(d));
    end
    @(posedge clk);
    if (st) refOffs++;
    if (fin) begin
      refLastSlot = refSlot;
      refLastLen  = refOffs;
      refSlot     = (refSlot + 1) % NSLOT;
      refOffs     = 0;
      refPend     = 1;
    end else if (clr) begin
      refPend = 0;
    end
    @(negedge clk);
    chk(int'(lastSlot) == refLastSlot, fin ? "R5" : "R9", int'(lastSlot), refLastSlot);
    chk(int'(lastLen) == refLastLen, fin ? "R4" : "R9", int'(lastLen), refLastLen);
    chk(int'(rxPending) == refPend, "R7", int'(rxPending), refPend);
  endtask

  task automatic sendFrame(input int len, input int seed, input bit gaps, input bit clrLast);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 2)) step(1'b0, 8'hEE, 1'b0, 1'b1, 1'b0);
      step(1'b1, 8'((seed + i * 7) & 255), i == len - 1, 1'b1, clrLast && (i == len - 1));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8: reset state
    chk(int'(lastSlot) == 0, "R8", int'(lastSlot), 0);
    chk(int'(lastLen) == 0, "R8", int'(lastLen), 0);
    chk(rxPending == 1'b0, "R8", int'(rxPending), 0);
    chk(memWe == 1'b0, "R8", int'(memWe), 0);

    sendFrame(5, 16, 1'b1, 1'b0);     // slot 0, gaps in stream
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1); // clear pending
    sendFrame(3, 40, 1'b0, 1'b0);     // slot 1
    sendFrame(1, 99, 1'b0, 1'b0);     // wraps to slot 0
    // R1/R9: disabled, offered frames must be refused
    for (int k = 0; k < 4; k++) step(1'b1, 8'h55, 1'b1, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    sendFrame(2, 7, 1'b0, 1'b1);      // clear and completion together
    sendFrame(SLOT, 3, 1'b0, 1'b0);   // exactly one slot
    sendFrame(SLOT + 3, 11, 1'b0, 1'b0); // truncated
    sendFrame(4, 200, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule